// File: doc/BRIEF.md
# Character FIFO with Fill-Level Interrupt and Stale-Data Watchdog

This block holds characters between a serial engine and a host bus. The engine writes characters into one end and the host reads them from the other. The storage holds `DEPTH` characters, 16 by default. A run-time mode input cuts the usable depth to half. When that input changes, both pointers and the fill count are cleared, so the contents start again from empty.

An interrupt is raised on one of four fill levels, chosen by a 2-bit selector. A receive instance (`IS_TX = 0`) measures how many characters are stored. A transmit instance (`IS_TX = 1`) measures how many slots are free. The levels scale with the active depth. The `full` and `empty` flags and the level output can drive DMA request lines directly.

On the receive side, a watchdog counts bit-time ticks while characters sit unread with no push or pop. It raises a stale flag after `IDLE_BITS` ticks. In time-out mode, the stale flag is also merged into the interrupt. A push that finds no room is dropped and sets a sticky overrun flag. An error-clear command clears that flag.

Top module: `ser_fifo_lvl`

## Requirements
- R1: After reset, `count` is 0, `empty` is 1, `full`, `overrun` and `stale` are 0, and `lvl_irq` is 0 on a receive instance.
- R2: Characters leave in arrival order. `pop_data` always shows the oldest stored character while `empty` is 0. `count` follows accepted pushes and pops, one edge after they are sampled.
- R3: A push while `count` equals the active capacity is discarded and sets `overrun`, unless a pop is accepted in the same cycle; in that case the push is accepted.
- R4: `clr_err` clears `overrun` at the next edge. A discarded push in the same cycle leaves it set.
- R5: The active capacity is `DEPTH` when `half_mode` is 0 and `DEPTH/2` when it is 1. `full` rises when `count` reaches that capacity.
- R6: In the cycle where `half_mode` differs from its value at the previous edge, push and pop are ignored. At the following edge, `count` becomes 0 and `empty` becomes 1. `overrun` is kept.
- R7: On a receive instance, `lvl_irq` level part is 1 when `count` is at least T. T is 1, cap/4, cap/2 or cap−cap/4 for `lvl_sel` 0, 1, 2, 3.
- R8: On a transmit instance, `lvl_irq` is 1 when the free slots (cap − `count`) are at least T. T is cap, cap/4, cap/2 or cap−cap/4 for `lvl_sel` 0, 1, 2, 3; value 0 means fully empty.
- R9: On a receive instance, `stale` rises after `IDLE_BITS` edges with `bit_tick` high, with the FIFO non-empty and no accepted push or pop. Any accepted push or pop, or an empty FIFO, restarts the count and clears `stale`.
- R10: On a receive instance with `tmo_en` at 1, `lvl_irq` is also 1 while `stale` is 1. On a transmit instance, `stale` stays 0.
- R11: A pop while `empty` is 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_mode | input | 1 | 1 selects half-depth operation |
| lvl_sel | input | 2 | Interrupt fill-level selector |
| tmo_en | input | 1 | Time-out mode: stale flag joins the interrupt |
| clr_err | input | 1 | Clears the overrun flag |
| bit_tick | input | 1 | One pulse per serial bit time |
| push | input | 1 | Write strobe from the serial engine |
| push_data | input | W | Character to write |
| pop | input | 1 | Read strobe from the host |
| pop_data | output | W | Oldest stored character |
| count | output | $clog2(DEPTH+1) | Characters stored |
| full | output | 1 | Count equals active capacity |
| empty | output | 1 | Count is zero |
| overrun | output | 1 | Sticky dropped-push flag |
| stale | output | 1 | Watchdog expiry flag |
| lvl_irq | output | 1 | Level interrupt / DMA request |

## Verification
A receive instance and a transmit instance share the same stimulus. This checks the stored-count and free-slot level rules against the same occupancy. Random phases with a fixed seed mix these cases:
- push-heavy, pop-heavy and balanced traffic, which reach the full, empty and middle regions at every level selector;
- silent phases with ticks running, which separate a watchdog that restarts on traffic from one that does not;
- occasional depth toggles, which expose flushing and half-depth level scaling.

Directed cases cover:
- the overrun boundary, including a push together with a pop while full;
- a clear in the same cycle as a drop;
- a pop on empty;
- the exact tick on which `stale` rises.

// File: rtl/ser_fifo_lvl.sv
module ser_fifo_lvl #(
  parameter int DEPTH     = 16,
  parameter int W         = 8,
  parameter int IDLE_BITS = 64,
  parameter bit IS_TX     = 1'b0,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH),
  localparam int IW = $clog2(IDLE_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_mode,
  input  logic [1:0]    lvl_sel,
  input  logic          tmo_en,
  input  logic          clr_err,
  input  logic          bit_tick,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          overrun,
  output logic          stale,
  output logic          lvl_irq
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cap, thr, room;
  logic [IW-1:0] idle;
  logic          half_q, ovf, flush, pop_ok, push_ok, drop, lvl_hit;

  assign cap     = half_q ? CW'(DEPTH / 2) : CW'(DEPTH);
  assign flush   = half_mode != half_q;
  assign empty   = cnt == '0;
  assign full    = cnt == cap;
  assign pop_ok  = pop & ~empty & ~flush;
  assign push_ok = push & ~flush & (~full | pop_ok);
  assign drop    = push & ~flush & ~push_ok;
  assign room    = cap - cnt;

  always_comb begin
    case (lvl_sel)
      2'd0:    thr = IS_TX ? cap : CW'(1);
      2'd1:    thr = cap >> 2;
      2'd2:    thr = cap >> 1;
      default: thr = cap - (cap >> 2);
    endcase
  end

  assign lvl_hit = IS_TX ? (room >= thr) : (cnt >= thr);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p, input logic [CW-1:0] c);
    return (CW'(p) == c - CW'(1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      half_q <= 1'b0;
    end else if (flush) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      half_q <= half_mode;
    end else begin
      if (push_ok) wp <= nxt(wp, cap);
      if (pop_ok)  rp <= nxt(rp, cap);
      if (push_ok && !pop_ok)      cnt <= cnt + CW'(1);
      else if (pop_ok && !push_ok) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf <= 1'b0;
    else        ovf <= (ovf & ~clr_err) | drop;
  end

  generate
    if (IS_TX) begin : g_tx
      assign idle = '0;
    end else begin : g_rx
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  idle <= '0;
        else if (flush || push_ok || pop_ok || empty) idle <= '0;
        else if (bit_tick && idle != IW'(IDLE_BITS))   idle <= idle + IW'(1);
      end
    end
  endgenerate

  assign stale    = !IS_TX && (idle == IW'(IDLE_BITS));
  assign overrun  = ovf;
  assign count    = cnt;
  assign pop_data = mem[rp];
  assign lvl_irq  = lvl_hit | (tmo_en & stale);

endmodule

module ser_fifo_lvl_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          half_mode,
  input logic          half_q,
  input logic          push,
  input logic          pop,
  input logic          clr_err,
  input logic [CW-1:0] count,
  input logic          full,
  input logic          empty,
  input logic          overrun,
  input logic          stale
);

  p_cap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (half_q ? CW'(DEPTH / 2) : CW'(DEPTH)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && half_mode == half_q) |=> (overrun && $stable(count)));

  p_err_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !push) |=> !overrun);

  p_mode_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (half_mode != half_q) |=> (count == '0));

  p_stale_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !stale);

  p_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

endmodule

bind ser_fifo_lvl ser_fifo_lvl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_mode(half_mode), .half_q(half_q),
  .push(push), .pop(pop), .clr_err(clr_err), .count(count), .full(full),
  .empty(empty), .overrun(overrun), .stale(stale)
);

// File: tb/ser_fifo_lvl_bench.sv
module ser_fifo_lvl_bench;
  localparam int DEPTH = 16, W = 8, IDLE = 64, CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic half_mode = 0, tmo_en = 0, clr_err = 0, bit_tick = 0, push = 0, pop = 0;
  logic [1:0] lvl_sel = 0;
  logic [W-1:0] push_data = 0;
  logic [W-1:0] rx_data, tx_data;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic rx_full, rx_empty, rx_ovf, rx_stale, rx_irq;
  logic tx_full, tx_empty, tx_ovf, tx_stale, tx_irq;

  always #10 clk = ~clk;

  ser_fifo_lvl #(.DEPTH(DEPTH), .W(W), .IDLE_BITS(IDLE), .IS_TX(1'b0)) u_ser_fifo_lvl (
    .clk, .rst_n, .half_mode, .lvl_sel, .tmo_en, .clr_err, .bit_tick, .push, .push_data, .pop,
    .pop_data(rx_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .overrun(rx_ovf), .stale(rx_stale), .lvl_irq(rx_irq));

  ser_fifo_lvl #(.DEPTH(DEPTH), .W(W), .IDLE_BITS(IDLE), .IS_TX(1'b1)) u_ser_fifo_lvl_tx (
    .clk, .rst_n, .half_mode, .lvl_sel, .tmo_en, .clr_err, .bit_tick, .push, .push_data, .pop,
    .pop_data(tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .overrun(tx_ovf), .stale(tx_stale), .lvl_irq(tx_irq));

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] q[$];
  bit m_half = 0, m_ovf = 0;
  int m_idle = 0;

  function automatic int cap_f(bit h);
    return h ? DEPTH / 2 : DEPTH;
  endfunction

  function automatic int thr_f(bit tx, int c, int s);
    case (s)
      0: return tx ? c : 1;
      1: return c / 4;
      2: return c / 2;
      default: return c - c / 4;
    endcase
  endfunction

  function automatic bit rx_irq_f(int n, int c, int s, bit t, bit st);
    return (n >= thr_f(0, c, s)) || (t && st);
  endfunction

  function automatic bit tx_irq_f(int n, int c, int s);
    return (c - n) >= thr_f(1, c, s);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit pop_ok, push_ok, flush, was_empty;
    int c;
    c = cap_f(m_half);
    flush = half_mode != m_half;
    was_empty = q.size() == 0;
    pop_ok = pop && !was_empty && !flush;
    push_ok = push && !flush && (q.size() < c || pop_ok);
    m_ovf = (m_ovf && !clr_err) || (push && !flush && !push_ok);
    if (flush) begin
      q.delete();
      m_half = half_mode;
    end else begin
      if (pop_ok) void'(q.pop_front());
      if (push_ok) q.push_back(push_data);
    end
    if (flush || push_ok || pop_ok || was_empty) m_idle = 0;
    else if (bit_tick && m_idle != IDLE) m_idle++;
  endtask

  task automatic check_all();
    int c;
    bit st;
    c = cap_f(m_half);
    st = m_idle == IDLE;
    chk("R2 rx count", int'(rx_cnt), q.size());
    chk("R2 tx count", int'(tx_cnt), q.size());
    chk("R2 empty", rx_empty, q.size() == 0);
    chk("R5 full", rx_full, q.size() == c);
    if (q.size() != 0) begin
      chk("R2 rx order", rx_data, q[0]);
      chk("R2 tx order", tx_data, q[0]);
    end
    chk("R3 overrun", rx_ovf, m_ovf);
    chk("R9 stale", rx_stale, st);
    chk("R10 tx stale", tx_stale, 0);
    chk("R7 R10 rx irq", rx_irq, rx_irq_f(q.size(), c, lvl_sel, tmo_en, st));
    chk("R8 tx irq", tx_irq, tx_irq_f(q.size(), c, lvl_sel));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle_in();
    push = 0; pop = 0; clr_err = 0; bit_tick = 0;
  endtask

  task automatic do_push(logic [W-1:0] d);
    idle_in(); push = 1; push_data = d; step(); idle_in();
  endtask

  task automatic do_pop();
    idle_in(); pop = 1; step(); idle_in();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset count", int'(rx_cnt), 0);
    chk("R1 reset empty", rx_empty, 1);
    chk("R1 reset full", rx_full, 0);
    chk("R1 reset overrun", rx_ovf, 0);
    chk("R1 reset stale", rx_stale, 0);
    chk("R1 reset irq", rx_irq, 0);

    do_pop();
    chk("R11 pop on empty", int'(rx_cnt), 0);

    for (int i = 0; i < DEPTH; i++) do_push(W'(8'h30 + i));
    chk("R5 full at DEPTH", rx_full, 1);
    lvl_sel = 2'd3; @(negedge clk); check_all();
    do_push(8'hEE);
    chk("R3 dropped push overrun", rx_ovf, 1);
    chk("R3 dropped push count", int'(rx_cnt), DEPTH);
    idle_in(); push = 1; pop = 1; push_data = 8'h77; step(); idle_in();
    chk("R3 push with pop at full", int'(rx_cnt), DEPTH);
    chk("R2 head after pop", rx_data, 8'h31);
    idle_in(); clr_err = 1; push = 1; push_data = 8'h55; step(); idle_in();
    chk("R4 drop beats clear", rx_ovf, 1);
    idle_in(); clr_err = 1; step(); idle_in();
    chk("R4 clear", rx_ovf, 0);

    half_mode = 1; push = 1; push_data = 8'h99; step(); idle_in();
    chk("R6 flush on mode change", int'(rx_cnt), 0);
    chk("R6 flush keeps empty", rx_empty, 1);
    for (int i = 0; i < DEPTH / 2; i++) do_push(W'(8'hA0 + i));
    chk("R5 full at half depth", rx_full, 1);
    for (int s = 0; s < 4; s++) begin
      lvl_sel = 2'(s); @(negedge clk); check_all();
    end
    while (q.size() > 1) do_pop();
    lvl_sel = 2'd3; tmo_en = 1;
    idle_in(); bit_tick = 1;
    for (int i = 0; i < IDLE - 1; i++) step();
    chk("R9 not yet stale", rx_stale, 0);
    step();
    chk("R9 stale at limit", rx_stale, 1);
    chk("R10 timeout irq", rx_irq, 1);
    idle_in(); do_pop();
    chk("R9 stale cleared by pop", rx_stale, 0);

    for (int ph = 0; ph < 40; ph++) begin
      int pp, pq;
      bit quiet;
      quiet = ($urandom % 5) == 0;
      pp = 10 + $urandom % 80;
      pq = 10 + $urandom % 80;
      lvl_sel = 2'($urandom);
      tmo_en = $urandom % 2;
      if ($urandom % 6 == 0) half_mode = ~half_mode;
      for (int k = 0; k < 100; k++) begin
        push = !quiet && ($urandom % 100) < pp;
        pop = !quiet && ($urandom % 100) < pq;
        push_data = W'($urandom);
        bit_tick = quiet ? 1'b1 : ($urandom % 2);
        clr_err = ($urandom % 30) == 0;
        step();
      end
      idle_in();
    end

    summary();
    $finish;
  end
endmodule